// File: doc/BRIEF.md
# Dual-Port Cell Buffer with Bypass

This block is a cell memory with one write-only port and one read-only port, each with its own address. In one cycle a cell can be stored at one location while another location is fetched. Reads go through a two-stage pipeline: a memory stage, then an output register. A combinational output enable gates what is visible on the data output.

A mode input lets an incoming cell skip the memory. In pass-through mode the cell is loaded straight into the output register and is not stored. In write-and-pass mode the cell is both forwarded and stored. Either way the cell reaches the output two edges sooner than a write followed by a read of the same location. When a forwarded cell and a pipelined read meet at the output register, the forwarded cell wins and a one-cycle clash flag is raised.

Depth and width are parameters. The storage array has no reset, so its contents are undefined until written.

Top module: `cell_buffer_dp`

## Requirements
- R1: A write to one address and a read of a different address, presented in the same cycle, both take effect. The read returns the contents that address held before that edge.
- R2: A read whose rd_addr is sampled with rd_en high at a rising edge has no effect on the outputs after that edge. Its data appears on dout, with dout_valid high, after the next rising edge.
- R3: If a read and a write target the same address at the same edge, the read returns the old contents, and the new data is stored for later reads.
- R4: While out_en is low, dout is zero and dout_valid is low. Raising out_en shows the held result within the same cycle, with no clock edge needed.
- R5: byp_mode encoding: 2'b00 is normal, 2'b01 is pass-through, 2'b10 is write-and-pass, and 2'b11 behaves exactly like 2'b00.
- R6: In pass-through mode, the wr_data sampled at an edge is on dout with dout_valid high right after that edge. It is not stored, even when wr_en is high.
- R7: In write-and-pass mode, wr_data is forwarded with the same timing as R6 and is also stored at wr_addr, whatever the value of wr_en.
- R8: A forwarded cell and a pipelined read that reach the output register at the same edge: the forwarded cell is shown, the read result is dropped, and bypass_clash is high for exactly that one cycle.
- R9: While rst_n is low, dout_valid and bypass_clash are low and dout is zero.
- R10: In the normal modes (00 and 11), a cell is stored only when wr_en is high. With wr_en low, the addressed location keeps its previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline state |
| wr_en | input | 1 | Store request for the normal modes |
| wr_addr | input | AW | Write location |
| wr_data | input | WIDTH | Incoming cell |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read location |
| out_en | input | 1 | Output enable, combinational gate on dout and dout_valid |
| byp_mode | input | 2 | 00 normal, 01 pass-through, 10 write-and-pass, 11 normal |
| dout | output | WIDTH | Output cell, zero when not valid |
| dout_valid | output | 1 | dout carries a cell |
| bypass_clash | output | 1 | A pipelined read was displaced by a forwarded cell |

## Verification
A stale memory-stage register or a write that lands in the wrong place shows up at the ports two edges after the affected read, as a wrong value on dout. This is why every address pair, including equal addresses, is read back right after a simultaneous write. A wrong valid stage shows either as dout_valid one edge early, or as a read result that never arrives. A broken bypass mux or mode decode shows on the very next edge: dout holds the wrong cell, or a later read-back reveals a store that should not have happened (or a missing one).

// File: rtl/cell_buffer_dp.sv
`timescale 1ns/1ps
module cell_buffer_dp #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic             out_en,
  input  logic [1:0]       byp_mode,
  output logic [WIDTH-1:0] dout,
  output logic             dout_valid,
  output logic             bypass_clash
);
  localparam logic [1:0] MODE_PASS  = 2'b01;
  localparam logic [1:0] MODE_WPASS = 2'b10;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] s1_data, out_q;
  logic             s1_vld, out_vld, clash_q;

  wire pass_only = (byp_mode == MODE_PASS);
  wire wr_pass   = (byp_mode == MODE_WPASS);
  wire fwd       = pass_only | wr_pass;
  wire store     = (wr_pass | (wr_en & ~pass_only)) & (32'(wr_addr) < DEPTH);

  always_ff @(posedge clk) begin
    if (store) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en && (32'(rd_addr) < DEPTH)) s1_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      out_vld <= 1'b0;
      out_q   <= '0;
      clash_q <= 1'b0;
    end else begin
      s1_vld  <= rd_en;
      out_vld <= fwd | s1_vld;
      out_q   <= fwd ? wr_data : s1_data;
      clash_q <= fwd & s1_vld;
    end
  end

  assign dout_valid   = out_en & out_vld;
  assign dout         = dout_valid ? out_q : '0;
  assign bypass_clash = clash_q;
endmodule

module cell_buffer_dp_chk #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic             rd_en,
  input logic [AW-1:0]    rd_addr,
  input logic             out_en,
  input logic [1:0]       byp_mode,
  input logic [WIDTH-1:0] dout,
  input logic             dout_valid,
  input logic             bypass_clash
);
  logic fwd;
  assign fwd = (byp_mode == 2'b01) || (byp_mode == 2'b10);

  p_read_arrives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rd_en, 2) && out_en) |-> dout_valid);

  p_forward_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fwd) && out_en) |-> (dout_valid && dout == $past(wr_data)));

  p_clash_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_clash |-> ($past(fwd) && $past(rd_en, 2)));

  p_drained_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && !$past(rd_en, 2) && !$past(fwd)) |-> (!dout_valid && !bypass_clash));
endmodule

bind cell_buffer_dp cell_buffer_dp_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_cell_buffer_dp.sv
`timescale 1ns/1ps
module test_cell_buffer_dp;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int WIDTH = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n, wr_en, rd_en, out_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [WIDTH-1:0] wr_data, dout;
  logic [1:0] byp_mode;
  logic dout_valid, bypass_clash;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [WIDTH-1:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  cell_buffer_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_cell_buffer_dp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .out_en(out_en), .byp_mode(byp_mode),
    .dout(dout), .dout_valid(dout_valid), .bypass_clash(bypass_clash));

  function automatic logic [WIDTH-1:0] pat(int a, int k);
    return WIDTH'((a * 29 + k * 7 + 3) & 8'hFF);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; byp_mode = 2'b00; wr_addr = '0; rd_addr = '0; wr_data = '0;
  endtask

  task automatic op(logic we, int wa, logic [WIDTH-1:0] wd, logic re, int ra, logic [1:0] m);
    wr_en = we; wr_addr = AW'(wa); wr_data = wd; rd_en = re; rd_addr = AW'(ra); byp_mode = m;
    tick();
    if (m == 2'b10 || (we && m != 2'b01)) model[wa] = wd;
    idle();
  endtask

  task automatic read_back(string tag, int a);
    op(0, 0, '0, 1, a, 2'b00);
    tick();
    chk(tag, {24'h0, dout}, {24'h0, model[a]});
    chk(tag, {31'h0, dout_valid}, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    out_en = 1; rst_n = 0;
    rd_en = 1; byp_mode = 2'b01; wr_data = 8'hFF;
    repeat (3) tick();
    // R9: reset state with activity on the inputs
    chk("R9 valid", {31'h0, dout_valid}, 32'h0);
    chk("R9 dout", {24'h0, dout}, 32'h0);
    chk("R9 clash", {31'h0, bypass_clash}, 32'h0);
    idle();
    rst_n = 1;
    tick();

    for (int a = 0; a < DEPTH; a++) op(1, a, pat(a, 0), 0, 0, 2'b00);

    // R1 / R3: every write/read address pair in the same cycle
    for (int wa = 0; wa < DEPTH; wa++) begin
      for (int ra = 0; ra < DEPTH; ra++) begin
        logic [WIDTH-1:0] exp_v;
        exp_v = model[ra];
        op(1, wa, pat(wa, wa * DEPTH + ra + 1), 1, ra, 2'b00);
        chk("R2 not early", {31'h0, dout_valid}, 32'h0);
        tick();
        chk(wa == ra ? "R3 old data" : "R1 parallel", {24'h0, dout}, {24'h0, exp_v});
        chk("R2 valid", {31'h0, dout_valid}, 32'h1);
      end
    end
    for (int a = 0; a < DEPTH; a++) read_back("R3 stored", a);

    // R4: output enable gating
    op(0, 0, '0, 1, 2, 2'b00);
    out_en = 0;
    tick();
    chk("R4 dout gated", {24'h0, dout}, 32'h0);
    chk("R4 valid gated", {31'h0, dout_valid}, 32'h0);
    out_en = 1;
    #1;
    chk("R4 dout shown", {24'h0, dout}, {24'h0, model[2]});
    chk("R4 valid shown", {31'h0, dout_valid}, 32'h1);
    tick();

    // R2: back-to-back reads stream
    for (int i = 0; i <= DEPTH + 1; i++) begin
      if (i <= DEPTH) op(0, 0, '0, 1, i % DEPTH, 2'b00);
      else tick();
      if (i >= 1) begin
        chk("R2 stream", {24'h0, dout}, {24'h0, model[(i - 1) % DEPTH]});
        chk("R2 stream valid", {31'h0, dout_valid}, 32'h1);
      end
    end
    tick();

    // R5 R6 R7 R10: every mode with wr_en low and high
    for (int m = 0; m < 4; m++) begin
      for (int we = 0; we < 2; we++) begin
        int a;
        logic [WIDTH-1:0] d;
        string tag;
        tag = (m == 1) ? "R6" : (m == 2) ? "R7" : (m == 3) ? "R5" : "R10";
        a = m * 2 + we;
        d = ~model[a];
        op(we[0], a, d, 0, 0, m[1:0]);
        if (m == 1 || m == 2) begin
          chk(tag, {24'h0, dout}, {24'h0, d});
          chk(tag, {31'h0, dout_valid}, 32'h1);
        end else begin
          chk(tag, {31'h0, dout_valid}, 32'h0);
        end
        tick();
        read_back(tag, a);
      end
    end

    // R8: forwarded cell meets a pipelined read
    op(0, 0, '0, 1, 2, 2'b00);
    op(1, 7, 8'h5A, 0, 0, 2'b01);
    chk("R8 bypass wins", {24'h0, dout}, 32'h5A);
    chk("R8 clash raised", {31'h0, bypass_clash}, 32'h1);
    tick();
    chk("R8 read dropped", {31'h0, dout_valid}, 32'h0);
    chk("R8 clash cleared", {31'h0, bypass_clash}, 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule